// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel Sequencer

This block is one DMA channel that follows a chain of command descriptors stored in memory. Each descriptor gives a link to the next descriptor, a control halfword, a byte count, a buffer address and up to fifteen inline words for the peripheral's registers. The channel reads these fields over a word-wide memory port. It writes the inline words to the peripheral register port. It then moves the buffer toward the peripheral, moves peripheral data into the buffer, or moves no data.

Software sets the first descriptor address and writes a semaphore count. The channel advances only while that count is nonzero. A descriptor can lower the count by one when it finishes, which makes the channel pause at the next descriptor boundary. A ring of descriptors can run without end if software adds one to the count on each completion interrupt. The current buffer position is always visible, so software can work out how many bytes remain.

Top module: `dseq_channel`

## Requirements
- R1: A descriptor at base B is read as four kinds of word, in this order: B+0 holds the link address, B+4 holds the control halfword in bits 15:0 and the byte count in bits 31:16, B+8 holds the buffer address, and B+12+4i holds inline word i. Buffer accesses follow these fetches.
- R2: Control halfword fields are: command in bits 1:0 (0 no data, 1 peripheral to memory, 2 memory to peripheral), chain in bit 2, completion interrupt in bit 3, wait-for-ready in bit 5, semaphore decrement in bit 6, wait-for-end in bit 7, and inline word count in bits 15:12.
- R3: The inline words are written one per cycle on the register port with index 0, 1, … in order. All of them are written before the descriptor's data phase.
- R4: With command 2, buffer words are read and offered on tx_data. On each handshake the current address grows by the smaller of 4 and the bytes left. The phase ends once count bytes are done, and a count of 0 moves no data.
- R5: With command 1, each rx_data word accepted is written to memory at the current address, with the same address advance as R4.
- R6: When chain is set, the link becomes the next descriptor address after completion. When chain is clear, the channel stops and busy falls.
- R7: While stopped, a nonzero semaphore write replaces the count, clears the error flag and starts fetching at the loaded next address. A next-address write is used only while stopped and is ignored at all other times.
- R8: A descriptor with the decrement bit lowers the count by one in its completion cycle. When a chained descriptor completes, the channel waits at the boundary while the count is zero, keeps busy high, and resumes once the count is raised.
- R9: A semaphore write while busy adds to the count, and the count saturates at 255.
- R10: irq is a single-cycle pulse in the completion cycle of any descriptor that has bit 3 set.
- R11: Wait-for-ready holds the channel before the data phase until dev_ready is high. Wait-for-end holds completion until dev_end is high.
- R12: A memory response with mem_err set stops the channel, sets err and sets err_code to 2.
- R13: A descriptor with command 3 or a byte count above 0xFF00 stops the channel with err set and err_code 1. A count of exactly 0xFF00 is accepted.
- R14: mem_req, mem_addr, mem_we and mem_wdata stay stable from the time a request is raised until the cycle mem_ack is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nxt_we | input | 1 | Load the next-descriptor address (honoured only while stopped) |
| nxt_addr | input | 32 | Next-descriptor address to load |
| sema_we | input | 1 | Semaphore write strobe |
| sema_val | input | 8 | Semaphore write value |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory response strobe |
| mem_err | input | 1 | Error response, valid with mem_ack |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| pio_we | output | 1 | Inline register write strobe |
| pio_idx | output | 4 | Inline register index |
| pio_wdata | output | 32 | Inline register data |
| tx_valid | output | 1 | Data word offered to the peripheral |
| tx_ready | input | 1 | Peripheral accepts tx_data |
| tx_data | output | 32 | Data word toward the peripheral |
| rx_valid | input | 1 | Peripheral offers rx_data |
| rx_ready | output | 1 | Channel accepts rx_data |
| rx_data | input | 32 | Data word from the peripheral |
| dev_ready | input | 1 | Peripheral ready for the data phase |
| dev_end | input | 1 | Peripheral signals end of its operation |
| irq | output | 1 | Completion pulse |
| busy | output | 1 | Channel not stopped |
| err | output | 1 | Channel stopped on an error |
| err_code | output | 2 | 1 bad descriptor, 2 bus error |
| cur_addr | output | 32 | Current buffer address |
| sema_cnt | output | 8 | Semaphore count |

## Verification
Some properties are checked on every cycle:
- a memory request stays stable while it waits for its response;
- a tx word stays stable while the peripheral stalls;
- the count never moves by more than one step unless software writes it;
- an add never makes the count smaller;
- irq never lasts more than one cycle;
- inline indices stay below the descriptor's count;
- err rises only together with the stop.

Some behaviours can be shown only by the bench's scenarios:
- the order of descriptor fetches;
- where the current address ends up for each byte count from 1 to 9;
- pausing on a zero count and resuming;
- the saturating add;
- the next-address write being ignored while the channel is busy;
- both error codes, and the acceptance of a count of exactly 0xFF00.

// File: rtl/dseq_pkg.sv
package dseq_pkg;
    localparam int AW        = 32;
    localparam int DW        = 32;
    localparam int CNT_W     = 16;
    localparam int NPIO_W    = 4;
    localparam int SEMA_W    = 8;
    localparam logic [CNT_W-1:0] MAX_BYTES = 16'hFF00;

    localparam logic [1:0] CMD_NONE  = 2'd0;
    localparam logic [1:0] CMD_TOMEM = 2'd1;
    localparam logic [1:0] CMD_TODEV = 2'd2;
    localparam logic [1:0] CMD_SENSE = 2'd3;

    localparam logic [1:0] ERR_NONE = 2'd0;
    localparam logic [1:0] ERR_DESC = 2'd1;
    localparam logic [1:0] ERR_BUS  = 2'd2;

    typedef struct packed {
        logic [1:0]        cmd;
        logic              chain;
        logic              irq;
        logic              wrdy;
        logic              dec;
        logic              wend;
        logic [NPIO_W-1:0] npio;
    } ctrl_t;

    typedef enum logic [3:0] {
        S_STOP, S_PAUSE, S_FNXT, S_FCTL, S_FBUF, S_FPIO, S_PIOW,
        S_WRDY, S_MRD, S_PPUT, S_PGET, S_MWR, S_WEND, S_DONE
    } st_e;
endpackage

// File: rtl/dseq_ctrl_decode.sv
module dseq_ctrl_decode
    import dseq_pkg::*;
(
    input  logic [15:0]      ctl_i,
    input  logic [CNT_W-1:0] cnt_i,
    output ctrl_t            fld_o,
    output logic             bad_o
);
    always_comb begin
        fld_o.cmd   = ctl_i[1:0];
        fld_o.chain = ctl_i[2];
        fld_o.irq   = ctl_i[3];
        fld_o.wrdy  = ctl_i[5];
        fld_o.dec   = ctl_i[6];
        fld_o.wend  = ctl_i[7];
        fld_o.npio  = ctl_i[15:12];
        bad_o       = (ctl_i[1:0] == CMD_SENSE) || (cnt_i > MAX_BYTES);
    end
endmodule

// File: rtl/dseq_advance.sv
module dseq_advance #(
    parameter int AW    = 32,
    parameter int CNT_W = 16,
    parameter int BPW   = 4
) (
    input  logic [AW-1:0]    cur_i,
    input  logic [CNT_W-1:0] rem_i,
    output logic [AW-1:0]    cur_o,
    output logic [CNT_W-1:0] rem_o
);
    logic [CNT_W-1:0] step;
    always_comb begin
        step  = (rem_i > CNT_W'(BPW)) ? CNT_W'(BPW) : rem_i;
        cur_o = cur_i + AW'(step);
        rem_o = rem_i - step;
    end
endmodule

// File: rtl/dseq_sema.sv
module dseq_sema #(
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [SW-1:0] val_i,
    input  logic          add_i,
    input  logic          dec_i,
    output logic [SW-1:0] cnt_o
);
    localparam logic [SW:0] TOP = {1'b0, {SW{1'b1}}};

    logic [SW-1:0] cnt_d, cnt_q;
    logic [SW:0]   sum;

    always_comb begin
        sum   = {1'b0, cnt_q} + {1'b0, val_i};
        cnt_d = cnt_q;
        if (wr_i) begin
            if (add_i) cnt_d = (sum > TOP) ? TOP[SW-1:0] : sum[SW-1:0];
            else       cnt_d = val_i;
        end
        if (dec_i && cnt_d != '0) cnt_d = cnt_d - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    // R9: an add without a decrement never lowers the count
    p_add_mono_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && add_i && !dec_i) |=> (cnt_q >= $past(cnt_q)));
endmodule

// File: rtl/dseq_channel.sv
module dseq_channel
    import dseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nxt_we,
    input  logic [AW-1:0]     nxt_addr,
    input  logic              sema_we,
    input  logic [SEMA_W-1:0] sema_val,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [DW-1:0]     mem_rdata,
    output logic              pio_we,
    output logic [NPIO_W-1:0] pio_idx,
    output logic [DW-1:0]     pio_wdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [DW-1:0]     tx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [DW-1:0]     rx_data,
    input  logic              dev_ready,
    input  logic              dev_end,
    output logic              irq,
    output logic              busy,
    output logic              err,
    output logic [1:0]        err_code,
    output logic [AW-1:0]     cur_addr,
    output logic [SEMA_W-1:0] sema_cnt
);
    localparam int BPW = DW / 8;
    localparam logic [AW-1:0] OFS_CTL = AW'(BPW);
    localparam logic [AW-1:0] OFS_BUF = AW'(2 * BPW);
    localparam logic [AW-1:0] OFS_PIO = AW'(3 * BPW);

    typedef struct packed {
        st_e               st;
        logic [AW-1:0]     nxt;
        logic [AW-1:0]     link;
        logic [AW-1:0]     desc;
        ctrl_t             ctl;
        logic [CNT_W-1:0]  rem;
        logic [AW-1:0]     cur;
        logic [NPIO_W-1:0] pio_i;
        logic [DW-1:0]     wbuf;
        logic              err;
        logic [1:0]        ecode;
    } chan_t;

    chan_t q, d;

    ctrl_t            dec_fld;
    logic             dec_bad;
    logic [AW-1:0]    adv_cur;
    logic [CNT_W-1:0] adv_rem;
    logic             sema_dec;
    st_e              end_st, data_st, post_pio_st, after_step_st;

    dseq_ctrl_decode u_dec (
        .ctl_i (mem_rdata[15:0]),
        .cnt_i (mem_rdata[31:16]),
        .fld_o (dec_fld),
        .bad_o (dec_bad)
    );

    dseq_advance #(.AW(AW), .CNT_W(CNT_W), .BPW(BPW)) u_adv (
        .cur_i (q.cur),
        .rem_i (q.rem),
        .cur_o (adv_cur),
        .rem_o (adv_rem)
    );

    dseq_sema #(.SW(SEMA_W)) u_sema (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_i  (sema_we),
        .val_i (sema_val),
        .add_i (busy),
        .dec_i (sema_dec),
        .cnt_o (sema_cnt)
    );

    // phase targets shared by several states
    always_comb begin
        end_st = q.ctl.wend ? S_WEND : S_DONE;
        if (q.ctl.cmd == CMD_NONE || q.rem == '0) data_st = end_st;
        else if (q.ctl.cmd == CMD_TODEV)          data_st = S_MRD;
        else                                      data_st = S_PGET;
        post_pio_st   = q.ctl.wrdy ? S_WRDY : data_st;
        after_step_st = (adv_rem == '0) ? end_st
                      : ((q.ctl.cmd == CMD_TODEV) ? S_MRD : S_PGET);
    end

    always_comb begin
        d        = q;
        sema_dec = 1'b0;
        unique case (q.st)
            S_STOP: begin
                if (nxt_we) d.nxt = nxt_addr;
                if (sema_we && sema_val != '0) begin
                    d.desc  = nxt_we ? nxt_addr : q.nxt;
                    d.err   = 1'b0;
                    d.ecode = ERR_NONE;
                    d.st    = S_FNXT;
                end
            end
            S_PAUSE: if (sema_cnt != '0) begin
                d.desc = q.nxt;
                d.st   = S_FNXT;
            end
            S_FNXT: if (mem_ack) begin
                d.link = mem_rdata;
                d.st   = S_FCTL;
            end
            S_FCTL: if (mem_ack) begin
                d.ctl = dec_fld;
                d.rem = mem_rdata[31:16];
                if (dec_bad) begin
                    d.st    = S_STOP;
                    d.err   = 1'b1;
                    d.ecode = ERR_DESC;
                end else begin
                    d.st = S_FBUF;
                end
            end
            S_FBUF: if (mem_ack) begin
                d.cur   = mem_rdata;
                d.pio_i = '0;
                d.st    = (q.ctl.npio != '0) ? S_FPIO : post_pio_st;
            end
            S_FPIO: if (mem_ack) begin
                d.wbuf = mem_rdata;
                d.st   = S_PIOW;
            end
            S_PIOW: begin
                d.pio_i = q.pio_i + 1'b1;
                d.st    = (q.pio_i + 1'b1 == q.ctl.npio) ? post_pio_st : S_FPIO;
            end
            S_WRDY: if (dev_ready) d.st = data_st;
            S_MRD: if (mem_ack) begin
                d.wbuf = mem_rdata;
                d.st   = S_PPUT;
            end
            S_PPUT: if (tx_ready) begin
                d.cur = adv_cur;
                d.rem = adv_rem;
                d.st  = after_step_st;
            end
            S_PGET: if (rx_valid) begin
                d.wbuf = rx_data;
                d.st   = S_MWR;
            end
            S_MWR: if (mem_ack) begin
                d.cur = adv_cur;
                d.rem = adv_rem;
                d.st  = after_step_st;
            end
            S_WEND: if (dev_end) d.st = S_DONE;
            S_DONE: begin
                sema_dec = q.ctl.dec;
                if (q.ctl.chain) begin
                    d.nxt = q.link;
                    d.st  = S_PAUSE;
                end else begin
                    d.st = S_STOP;
                end
            end
            default: d.st = S_STOP;
        endcase
        // a bus error on any memory access overrides the step taken above
        if (mem_req && mem_ack && mem_err) begin
            d.st    = S_STOP;
            d.err   = 1'b1;
            d.ecode = ERR_BUS;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_STOP;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        mem_req = (q.st == S_FNXT) || (q.st == S_FCTL) || (q.st == S_FBUF) ||
                  (q.st == S_FPIO) || (q.st == S_MRD)  || (q.st == S_MWR);
        mem_we  = (q.st == S_MWR);
        unique case (q.st)
            S_FCTL:       mem_addr = q.desc + OFS_CTL;
            S_FBUF:       mem_addr = q.desc + OFS_BUF;
            S_FPIO:       mem_addr = q.desc + OFS_PIO + AW'({q.pio_i, 2'b00});
            S_MRD, S_MWR: mem_addr = q.cur;
            default:      mem_addr = q.desc;
        endcase
    end

    assign mem_wdata = q.wbuf;
    assign pio_we    = (q.st == S_PIOW);
    assign pio_idx   = q.pio_i;
    assign pio_wdata = q.wbuf;
    assign tx_valid  = (q.st == S_PPUT);
    assign tx_data   = q.wbuf;
    assign rx_ready  = (q.st == S_PGET);
    assign irq       = (q.st == S_DONE) && q.ctl.irq;
    assign busy      = (q.st != S_STOP);
    assign err       = q.err;
    assign err_code  = q.ecode;
    assign cur_addr  = q.cur;

    // R14: a pending memory request holds address and direction
    p_req_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));
    // R4: a stalled tx word is held
    p_tx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
    // R12: the error flag rises only together with the stop
    p_err_stop_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> !busy);
    // R8: without a write the count moves by at most one step down
    p_sema_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !sema_we |=> ((sema_cnt == $past(sema_cnt)) ||
                      (sema_cnt == $past(sema_cnt) - 8'd1)));
    // R3: inline index stays below the descriptor's inline count
    p_pio_idx_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pio_we |-> (pio_idx < q.ctl.npio));
    // R10: completion interrupt is a single-cycle pulse
    p_irq_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
endmodule

// File: tb/tb_dseq_channel.sv
module tb_dseq_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nxt_we = 1'b0;
    logic [31:0] nxt_addr = '0;
    logic        sema_we = 1'b0;
    logic [7:0]  sema_val = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0, mem_err = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        pio_we;
    logic [3:0]  pio_idx;
    logic [31:0] pio_wdata;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic [31:0] tx_data;
    logic        rx_valid = 1'b1;
    logic        rx_ready;
    logic [31:0] rx_data = '0;
    logic        dev_ready = 1'b1, dev_end = 1'b1;
    logic        irq, busy, err;
    logic [1:0]  err_code;
    logic [31:0] cur_addr;
    logic [7:0]  sema_cnt;

    always #5 clk = ~clk;

    dseq_channel dut (.*);

    logic [31:0] mem [0:511];
    logic [31:0] addr_log [0:63];
    logic [31:0] tx_log [0:63];
    logic [3:0]  pidx_log [0:15];
    logic [31:0] pdat_log [0:15];
    int n_addr, n_tx, n_pio, n_irq, n_wr;
    int nchk = 0, nfail = 0, cyc = 0;
    int lat_wait = 0, n_acc = 0, rx_seq = 0;
    logic rx_took = 1'b0;
    logic err_en = 1'b0;
    logic [31:0] err_addr = '0;

    task automatic clear_logs();
        n_addr = 0; n_tx = 0; n_pio = 0; n_irq = 0; n_wr = 0;
    endtask

    // memory, peripheral and log models, all acting at the falling edge
    initial begin
        clear_logs();
        forever begin
            @(negedge clk);
            cyc++;
            if (mem_ack) begin
                mem_ack = 1'b0;
                mem_err = 1'b0;
            end else if (mem_req) begin
                if (lat_wait < (n_acc % 3)) lat_wait++;
                else begin
                    lat_wait = 0;
                    n_acc++;
                    mem_ack = 1'b1;
                    mem_err = err_en && (mem_addr == err_addr);
                    if (n_addr < 64) addr_log[n_addr] = mem_addr;
                    n_addr++;
                    if (mem_we) begin
                        mem[mem_addr[10:2]] = mem_wdata;
                        n_wr++;
                    end
                    mem_rdata = mem[mem_addr[10:2]];
                end
            end
            tx_ready = (cyc % 3) != 2;
            if (tx_valid && tx_ready) begin
                if (n_tx < 64) tx_log[n_tx] = tx_data;
                n_tx++;
            end
            if (rx_took) rx_seq++;
            rx_took = rx_ready && rx_valid;
            rx_data = 32'hA000_0000 + rx_seq;
            if (pio_we) begin
                if (n_pio < 16) begin
                    pidx_log[n_pio] = pio_idx;
                    pdat_log[n_pio] = pio_wdata;
                end
                n_pio++;
            end
            if (irq) n_irq++;
        end
    end

    initial begin
        while (cyc < 150000) @(negedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: run did not finish got=%0d exp=<150000", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

    task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic [15:0] mk(input logic [1:0] cmd, input logic chain,
        input logic ir, input logic wrdy, input logic dec, input logic wend,
        input logic [3:0] npio);
        return {npio, 2'b00, 1'b0, 1'b0, wend, dec, wrdy, 1'b0, ir, chain, cmd};
    endfunction

    task automatic put_desc(input logic [31:0] base, input logic [31:0] nxt,
        input logic [15:0] ctl, input logic [15:0] cnt, input logic [31:0] buff);
        mem[base[10:2]]     = nxt;
        mem[base[10:2] + 1] = {cnt, ctl};
        mem[base[10:2] + 2] = buff;
        for (int i = 0; i < int'(ctl[15:12]); i++)
            mem[base[10:2] + 3 + i] = 32'hC0DE_0000 + (base << 4) + i;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; nxt_we = 1'b0; sema_we = 1'b0;
        dev_ready = 1'b1; dev_end = 1'b1; err_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        clear_logs();
    endtask

    task automatic load_nxt(input logic [31:0] a);
        @(negedge clk); nxt_we = 1'b1; nxt_addr = a;
        @(negedge clk); nxt_we = 1'b0;
    endtask

    task automatic sema_write(input logic [7:0] v);
        @(negedge clk); sema_we = 1'b1; sema_val = v;
        @(negedge clk); sema_we = 1'b0;
    endtask

    task automatic wait_stop();
        int w = 0;
        while (busy && w < 4000) begin
            @(negedge clk);
            w++;
        end
    endtask

    initial begin
        int bad;
        logic [31:0] exp_addr [0:7];
        for (int i = 0; i < 512; i++) mem[i] = 32'h5000_0000 + i;
        do_reset();

        // reset state (R7 start condition)
        check({31'd0, busy}, 0, "R7 busy after reset");
        check({30'd0, err_code}, 0, "R12 err_code after reset");
        check({24'd0, sema_cnt}, 0, "R8 count after reset");

        // single descriptor, memory to peripheral with two inline words
        put_desc(32'h000, 32'h0, mk(2'd2, 0, 1, 0, 1, 0, 4'd2), 16'd10, 32'h400);
        load_nxt(32'h000);
        sema_write(8'd1);
        wait_stop();
        exp_addr = '{32'h000, 32'h004, 32'h008, 32'h00C, 32'h010,
                     32'h400, 32'h404, 32'h408};
        bad = 0;
        for (int i = 0; i < 8; i++) if (addr_log[i] !== exp_addr[i]) bad++;
        check(bad, 0, "R1 R14 fetch order");
        check(n_pio, 2, "R3 inline write count");
        check({28'd0, pidx_log[0]}, 0, "R3 inline index 0");
        check(pdat_log[1], 32'hC0DE_0001, "R3 inline data 1");
        check(n_tx, 3, "R2 R4 tx word count");
        check(tx_log[2], mem[32'h408 >> 2], "R4 last tx word");
        check(cur_addr, 32'h40A, "R4 final address");
        check(n_irq, 1, "R10 irq count");
        check({24'd0, sema_cnt}, 0, "R8 decrement on completion");
        check({31'd0, busy}, 0, "R6 stop without chain");

        // chained pair: peripheral to memory, then wait-for-end
        clear_logs();
        rx_seq = 0;
        dev_end = 1'b0;
        put_desc(32'h040, 32'h080, mk(2'd1, 1, 0, 0, 0, 0, 4'd0), 16'd8, 32'h500);
        put_desc(32'h080, 32'h0, mk(2'd0, 0, 1, 0, 1, 1, 4'd0), 16'd0, 32'h0);
        load_nxt(32'h040);
        sema_write(8'd1);
        repeat (100) @(negedge clk);
        check(n_wr, 2, "R5 R14 memory writes");
        check(mem[32'h500 >> 2], 32'hA000_0000, "R5 first word");
        check(mem[32'h504 >> 2], 32'hA000_0001, "R5 second word");
        check(addr_log[5], 32'h080, "R6 chained fetch");
        check({31'd0, busy}, 1, "R11 held by wait-for-end");
        check(n_irq, 0, "R11 no irq before end");
        load_nxt(32'h0C0);
        dev_end = 1'b1;
        wait_stop();
        check(n_irq, 1, "R11 irq after end");
        clear_logs();
        sema_write(8'd1);
        wait_stop();
        check(addr_log[0], 32'h080, "R7 next write ignored while busy");

        // self-looping ring: pause at zero, resume on add
        do_reset();
        put_desc(32'h0C0, 32'h0C0, mk(2'd0, 1, 1, 0, 1, 0, 4'd0), 16'd0, 32'h0);
        load_nxt(32'h0C0);
        sema_write(8'd3);
        repeat (150) @(negedge clk);
        check(n_irq, 3, "R8 three passes");
        check({31'd0, busy}, 1, "R8 paused, still busy");
        check({24'd0, sema_cnt}, 0, "R8 paused count");
        sema_write(8'd2);
        repeat (150) @(negedge clk);
        check(n_irq, 5, "R8 resume after add");

        // saturating add while held in wait-for-ready
        do_reset();
        dev_ready = 1'b0;
        put_desc(32'h100, 32'h100, mk(2'd0, 1, 1, 1, 1, 0, 4'd0), 16'd0, 32'h0);
        load_nxt(32'h100);
        sema_write(8'd1);
        repeat (30) @(negedge clk);
        check(n_irq, 0, "R11 held by wait-for-ready");
        sema_write(8'd200);
        check({24'd0, sema_cnt}, 201, "R9 add while busy");
        sema_write(8'd100);
        check({24'd0, sema_cnt}, 255, "R9 saturation");

        // bus error and descriptor errors
        do_reset();
        put_desc(32'h140, 32'h0, mk(2'd0, 0, 0, 0, 0, 0, 4'd0), 16'd0, 32'h0);
        err_en = 1'b1; err_addr = 32'h148;
        load_nxt(32'h140);
        sema_write(8'd1);
        wait_stop();
        check({31'd0, err}, 1, "R12 error flag");
        check({30'd0, err_code}, 2, "R12 bus error code");
        err_en = 1'b0;
        put_desc(32'h180, 32'h0, mk(2'd3, 0, 0, 0, 0, 0, 4'd0), 16'd0, 32'h0);
        load_nxt(32'h180);
        sema_write(8'd1);
        wait_stop();
        check({30'd0, err_code}, 1, "R13 sense command rejected");
        put_desc(32'h1C0, 32'h0, mk(2'd0, 0, 0, 0, 0, 0, 4'd0), 16'hFF01, 32'h0);
        load_nxt(32'h1C0);
        sema_write(8'd1);
        wait_stop();
        check({30'd0, err_code}, 1, "R13 count above limit");
        clear_logs();
        put_desc(32'h200, 32'h0, mk(2'd0, 0, 1, 0, 0, 0, 4'd0), 16'hFF00, 32'h0);
        load_nxt(32'h200);
        sema_write(8'd1);
        wait_stop();
        check({31'd0, err}, 0, "R13 limit accepted, R7 error cleared");
        check(n_irq, 1, "R13 limit descriptor completes");

        // byte-count sweep for the address advance
        for (int n = 1; n <= 9; n++) begin
            put_desc(32'h240, 32'h0, mk(2'd2, 0, 0, 0, 0, 0, 4'd0), 16'(n), 32'h600);
            clear_logs();
            load_nxt(32'h240);
            sema_write(8'd1);
            wait_stop();
            check(cur_addr, 32'h600 + n, "R4 sweep final address");
            check(n_tx, (n + 3) / 4, "R4 sweep word count");
            check(tx_log[(n + 3) / 4 - 1], mem[(32'h600 >> 2) + (n + 3) / 4 - 1],
                  "R4 sweep last word");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end
endmodule